// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A 32-pin general-purpose I/O bank behind a small memory-mapped register bus. Software drives pins through an output-data register and an output-enable register, and reads the synchronised pin levels from an input register. Any pin can also feed an interrupt detector. Per pin, the detector watches for a rising edge, a falling edge, a high level or a low level. Each detected event latches a sticky status bit, and the status bits, masked by per-pin enables, are ORed into one bank interrupt line.

Every writable register sits in its own 16-byte slot, and the slot has three write flavours: plain write, set alias (OR in the mask) and clear alias (AND out the mask). With the aliases, software can change single bits without a read-modify-write. Status bits can only be removed through the clear alias. A pin must be routed to the detector before it can latch status. It must also be enabled before that status can reach the interrupt line.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, pin_out and pin_oe are zero and bank_irq is low.
- R2: Register slot is bus_addr[6:4] (0 output data, 1 input data, 2 output enable, 3 routing, 4 interrupt enable, 5 level select, 6 polarity, 7 status). The write flavour is bus_addr[3:2]: 0 replaces the register, 1 ORs bus_wdata in, 2 clears the bits set in bus_wdata. Every address of a slot reads back the register value combinationally.
- R3: pin_out always equals the output-data register and pin_oe always equals the output-enable register.
- R4: The input-data register is read-only. It shows pin_in delayed by two clock edges through a synchroniser, whatever the output-enable setting.
- R5: With {polarity, level} = 10, a 0-to-1 change of a routed pin's synchronised level sets its status bit. The bit is set on the third rising clock edge after pin_in changes, and it stays set while the pin stays high.
- R6: With {polarity, level} = 00, a 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R7: With {polarity, level} = 11 or 01, the status bit is set on every cycle the high or low level persists, so a clear does not stick while the level is active.
- R8: A pin whose routing bit is 0 never sets its status bit.
- R9: Status bits are cleared only by the clear alias of slot 7. Plain and set-alias writes to slot 7, and any write to slot 1, have no effect.
- R10: bank_irq is high exactly when some status bit and its interrupt-enable bit are both 1.
- R11: When a detected event and a clear-alias write hit the same status bit in one cycle, the bit ends set.
- R12: Writes with bus_addr[1:0] not 00, or with flavour 3, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte address within the bank |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output data toward the pads |
| pin_oe | output | 32 | Output enable toward the pads, 1 drives |
| bank_irq | output | 1 | Bank interrupt request |

## Verification
The bench targets the level modes after a clear. A design that latched level events only once would leave status low while the level was still active. It fires a detection and a clear-alias write at the same status bit in one cycle, where a clear-priority design would lose the event. It routes a pin whose level is active but whose routing bit is clear, and writes status through the plain and set addresses, to catch status set from unrouted pins or set by software. It also checks that disabled status holds bank_irq low, and that misaligned and flavour-3 writes leave every register untouched.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int ADDR_W = 7;
  localparam int NSLOT  = 8;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_RSVD  = 2'd3
  } alias_op_e;

  typedef enum logic [2:0] {
    SLOT_DOUT  = 3'd0,
    SLOT_DIN   = 3'd1,
    SLOT_OE    = 3'd2,
    SLOT_ROUTE = 3'd3,
    SLOT_IEN   = 3'd4,
    SLOT_LVL   = 3'd5,
    SLOT_POL   = 3'd6,
    SLOT_STAT  = 3'd7
  } slot_e;
endpackage

// File: rtl/gpio_alias_reg.sv
`timescale 1ns/1ps
module gpio_alias_reg
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  alias_op_e    op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] alias_apply(logic [W-1:0] old, logic [W-1:0] mask, alias_op_e f);
    case (f)
      OP_WRITE: return mask;
      OP_SET:   return old | mask;
      OP_CLEAR: return old & ~mask;
      default:  return old;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= alias_apply(q, wdata, op);
  end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl_now,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= '0;
      lvl_now  <= '0;
      lvl_prev <= '0;
    end else begin
      meta_q   <= raw;
      lvl_now  <= meta_q;
      lvl_prev <= lvl_now;
    end
  end
endmodule

// File: rtl/gpio_evt_detect.sv
`timescale 1ns/1ps
module gpio_evt_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] lvl_now,
  input  logic [W-1:0] lvl_prev,
  input  logic [W-1:0] sel_level,
  input  logic [W-1:0] sel_high,
  input  logic [W-1:0] route,
  output logic [W-1:0] set_ev
);
  // level mode: active when the pin equals the polarity bit
  // edge mode: active when the pin just moved to the polarity value
  function automatic logic trig_hit(logic lvl_mode, logic pol, logic now, logic prev);
    if (lvl_mode) return now == pol;
    return (now == pol) && (prev != pol);
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign set_ev[i] = route[i] & trig_hit(sel_level[i], sel_high[i], lvl_now[i], lvl_prev[i]);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              bank_irq
);
  logic [2:0]       slot;
  alias_op_e        op;
  logic             wr_ok;
  logic             clr_stat_hit;
  logic [NPINS-1:0] view [NSLOT];
  logic [NPINS-1:0] din_q, prev_q, stat_q, set_ev;
  logic [NPINS-1:0] route_q, ien_q, lvl_q, pol_q;

  assign slot  = bus_addr[6:4];
  assign op    = alias_op_e'(bus_addr[3:2]);
  assign wr_ok = bus_wr && (bus_addr[1:0] == 2'b00);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g == int'(SLOT_DIN)) begin : g_din
      assign view[g] = din_q;
    end else if (g == int'(SLOT_STAT)) begin : g_stat
      assign view[g] = stat_q;
    end else begin : g_ctl
      gpio_alias_reg #(.W(NPINS)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ok && (slot == 3'(g))),
        .op    (op),
        .wdata (bus_wdata),
        .q     (view[g])
      );
    end
  end

  assign pin_out   = view[SLOT_DOUT];
  assign pin_oe    = view[SLOT_OE];
  assign route_q   = view[SLOT_ROUTE];
  assign ien_q     = view[SLOT_IEN];
  assign lvl_q     = view[SLOT_LVL];
  assign pol_q     = view[SLOT_POL];
  assign bus_rdata = view[slot];

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (pin_in),
    .lvl_now  (din_q),
    .lvl_prev (prev_q)
  );

  gpio_evt_detect #(.W(NPINS)) u_det (
    .lvl_now   (din_q),
    .lvl_prev  (prev_q),
    .sel_level (lvl_q),
    .sel_high  (pol_q),
    .route     (route_q),
    .set_ev    (set_ev)
  );

  assign clr_stat_hit = wr_ok && (slot == SLOT_STAT) && (op == OP_CLEAR);

  // detection is ORed in after the clear, so a same-cycle event survives
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~(clr_stat_hit ? bus_wdata : '0)) | set_ev;
  end

  assign bank_irq = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
`timescale 1ns/1ps
module gpio_irq_bank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bank_irq,
  input logic             clr_stat_hit,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] route_q,
  input logic [NPINS-1:0] set_ev
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !bank_irq);

  a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq |-> (stat_q != '0));

  a_r9_clear_only_by_alias: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stat_hit |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r8_route_gate: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(route_q)) == '0));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev != '0) |=> ((stat_q & $past(set_ev)) == $past(set_ev)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bank_irq     (bank_irq),
  .clr_stat_hit (clr_stat_hit),
  .stat_q       (stat_q),
  .route_q      (route_q),
  .set_ev       (set_ev)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        bank_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_reg [8];   // index = slot; slot 1 mirrors m_s2
  logic [31:0] m_s1, m_s2, m_prev;

  always @(posedge clk) begin
    logic [31:0] ev;
    int s, f;
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) m_reg[k] = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        bit hit;
        if (m_reg[5][i]) hit = (m_s2[i] == m_reg[6][i]);
        else if (m_reg[6][i]) hit = m_s2[i] && !m_prev[i];
        else hit = !m_s2[i] && m_prev[i];
        ev[i] = hit && m_reg[3][i];
      end
      s = int'(bus_addr[6:4]);
      f = int'(bus_addr[3:2]);
      if (bus_wr && bus_addr[1:0] == 0) begin
        if (s == 7) begin
          if (f == 2) m_reg[7] = m_reg[7] & ~bus_wdata;
        end else if (s != 1) begin
          if (f == 0) m_reg[s] = bus_wdata;
          else if (f == 1) m_reg[s] = m_reg[s] | bus_wdata;
          else if (f == 2) m_reg[s] = m_reg[s] & ~bus_wdata;
        end
      end
      m_reg[7] = m_reg[7] | ev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      m_reg[1] = m_s2;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // lockstep compare just after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R2 lockstep rdata", bus_rdata, m_reg[bus_addr[6:4]]);
      chk("R3 lockstep pin_out", pin_out, m_reg[0]);
      chk("R3 lockstep pin_oe", pin_oe, m_reg[2]);
      chk("R10 lockstep irq", {31'd0, bank_irq}, {31'd0, |(m_reg[7] & m_reg[4])});
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [6:0] ad(int slot, int op);
    return 7'(slot * 16 + op * 4);
  endfunction

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic drive_pins(logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int sl = 0; sl < 8; sl++) begin
      rd(ad(sl, 0), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq", {31'd0, bank_irq}, 0);
    chk("R1 reset pin_oe", pin_oe, 0);

    // R2 aliases on output data
    wr(ad(0, 0), 32'h1234_5678);
    wr(ad(0, 1), 32'h8000_0001);
    rd(ad(0, 0), v); chk("R2 set alias", v, 32'h9234_5679);
    wr(ad(0, 2), 32'h0000_0078);
    rd(ad(0, 1), v); chk("R2 clear alias via set addr read", v, 32'h9234_5601);
    chk("R3 pin_out", pin_out, 32'h9234_5601);

    // R12 misaligned and flavour-3 writes ignored
    wr(7'h01, 32'h0);
    wr(ad(0, 3), 32'h0);
    rd(ad(0, 0), v); chk("R12 ignored writes", v, 32'h9234_5601);

    // R3 / R4 direction and input sampling
    wr(ad(2, 0), 32'hFFFF_0000);
    chk("R3 pin_oe", pin_oe, 32'hFFFF_0000);
    drive_pins(32'hA5A5_5A5A);
    rd(ad(1, 0), v); chk("R4 input read", v, 32'hA5A5_5A5A);
    wr(ad(1, 0), 32'h0);
    rd(ad(1, 2), v); chk("R4 input read-only", v, 32'hA5A5_5A5A);
    drive_pins(32'h0);

    // configure: pin0 rising, pin1 falling, pin2 high level, pin3 low level
    wr(ad(5, 0), 32'h0000_000C);
    wr(ad(6, 0), 32'h0000_0005);
    wr(ad(3, 0), 32'h0000_000F);
    wr(ad(4, 0), 32'h0000_000F);
    repeat (3) @(negedge clk);
    rd(ad(7, 0), v); chk("R7 low level sets", v, 32'h8);
    wr(ad(7, 2), 32'h8);
    rd(ad(7, 0), v); chk("R7 clear does not stick", v, 32'h8);
    drive_pins(32'h8);
    wr(ad(7, 2), 32'h8);
    rd(ad(7, 0), v); chk("R7 clear after level ends", v, 32'h0);

    drive_pins(32'h9);
    rd(ad(7, 0), v); chk("R5 rising edge", v, 32'h1);
    chk("R10 irq raised", {31'd0, bank_irq}, 1);
    drive_pins(32'hB);
    rd(ad(7, 0), v); chk("R6 rise ignored in falling mode", v, 32'h1);
    drive_pins(32'h9);
    rd(ad(7, 0), v); chk("R6 falling edge", v, 32'h3);

    // R9 writes other than the clear alias leave status alone
    wr(ad(7, 0), 32'h0);
    wr(ad(7, 1), 32'hFFFF_FFFF);
    rd(ad(7, 0), v); chk("R9 plain/set writes ignored", v, 32'h3);
    wr(ad(7, 2), 32'h3);
    repeat (3) @(negedge clk);
    rd(ad(7, 0), v); chk("R9 clear, R5 edge stays cleared", v, 32'h0);

    // R10 enable masking
    drive_pins(32'hD);
    wr(ad(4, 0), 32'h0);
    rd(ad(7, 0), v); chk("R10 status with enables off", v, 32'h4);
    chk("R10 irq masked", {31'd0, bank_irq}, 0);
    wr(ad(4, 1), 32'h4);
    chk("R10 irq unmasked", {31'd0, bank_irq}, 1);

    // R8 routing gate
    wr(ad(3, 2), 32'h4);
    wr(ad(7, 2), 32'h4);
    repeat (3) @(negedge clk);
    rd(ad(7, 0), v); chk("R8 unrouted level", v, 32'h0);
    chk("R8 irq low", {31'd0, bank_irq}, 0);

    // R11 set beats clear on the same cycle (pin4 rising)
    wr(ad(6, 1), 32'h10);
    wr(ad(3, 1), 32'h10);
    @(negedge clk); pin_in = 32'h1D;
    @(negedge clk);
    wr(ad(7, 2), 32'h10);
    rd(ad(7, 0), v); chk("R11 set wins", v, 32'h10);
    wr(ad(7, 2), 32'h10);
    rd(ad(7, 0), v); chk("R11 later clear", v, 32'h0);

    // random traffic against the reference
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      bus_wr    = ($urandom_range(0, 2) == 0);
      bus_addr  = 7'($urandom);
      if ($urandom_range(0, 7) != 0) bus_addr[1:0] = 2'b00;
      bus_wdata = $urandom;
      if ($urandom_range(0, 3) == 0) pin_in = $urandom;
    end
    @(negedge clk); bus_wr = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule